// File: doc/BRIEF.md
# Oversampled Serial Receiver with Ready-to-Send Output

This block receives asynchronous serial characters of eight data bits, no parity and one stop bit. Each bit is divided into a programmable number of oversampling ticks, sixteen by default. A programmable clock divider produces those ticks. A falling edge on the line opens a candidate start bit. The receiver confirms it at mid-bit and then samples each data bit and the stop bit at their centres, least significant bit first.

Each finished character goes into a single holding register. Software polls the full flag and takes the byte with a one-cycle read strobe. The active-low ready-to-send output tells the remote transmitter when it may send. When the feature is on, the output goes high (stop) while the holding register is occupied. It also goes high as soon as a start bit has been detected, because that incoming character will occupy the register. It returns low only when the register is empty and no character is in flight.

Top module: `rx_flow_uart`

## Requirements
- R1: After reset, fullFlag, frameErr and overrunFlag are 0 and rtsN is 0.
- R2: A frame consisting of a low start bit, eight data bits sent least significant bit first, and a stop bit is stored in rxByte. fullFlag is set before the stop bit ends.
- R3: A one-cycle readStb pulse while fullFlag is 1 clears fullFlag, frameErr and overrunFlag. A readStb pulse while fullFlag is 0 changes none of them.
- R4: A frame whose stop bit is sampled low is still stored, and frameErr is set to 1 together with it. A frame whose stop bit is high stores frameErr as 0.
- R5: A frame that completes while fullFlag is 1 and no read happens in the same cycle is discarded. rxByte keeps the earlier byte, and overrunFlag is set.
- R6: With rtsEnable at 1, rtsN is 1 whenever fullFlag is 1.
- R7: With rtsEnable at 1, rtsN goes to 1 once a start bit is detected, even if the register is empty. It stays 1 until the frame is stored and read, including when a read happens while that frame is still arriving.
- R8: If the line is high again at the mid-bit sample of a start bit, with rtsEnable at 1, nothing is stored and rtsN returns to 0. The next full frame is received correctly.
- R9: With rtsEnable at 0, rtsN stays 0 both while a frame arrives and while the register is full.
- R10: One bit lasts (baudDiv+1)*(osrSel+1) clock cycles. Reception is correct for osrSel values 3, 7 and 15 and for baudDiv values 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| readStb | input | 1 | One-cycle read of the holding register |
| rtsEnable | input | 1 | 1 enables ready-to-send flow control |
| baudDiv | input | BAUD_W | Clock cycles per oversampling tick, minus one |
| osrSel | input | OSR_W | Oversampling ticks per bit, minus one |
| rxByte | output | DATA_BITS | Last stored character |
| fullFlag | output | 1 | Holding register occupied |
| frameErr | output | 1 | Stored character had a low stop bit |
| overrunFlag | output | 1 | A character was lost while the register was full |
| rtsN | output | 1 | Active-low ready-to-send |

## Verification
The bench probes rtsN inside the start bit of a frame that is arriving into an empty register. A design that deasserted only on a full register would show rtsN low there. The bench also issues a read in the middle of a frame, which catches a design that releases rtsN while a character is still arriving. A glitch that is too short to survive the mid-bit check must leave rtsN low and the register empty. A receiver that trusted the first low sample would store a spurious byte. A second frame sent into a full register must leave the first byte intact, which exposes a design that overwrites instead of flagging the loss.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic shiftEn;   // capture one data bit
    logic bitVal;    // value of the captured bit
    logic charDone;  // stop bit sampled this cycle
    logic stopOk;    // stop bit was high
    logic busy;      // a character is in flight
  } rxStrobe_t;
endpackage

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rx_flow_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BAUD_W    = 8,
  parameter int OSR_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  logic [BAUD_W-1:0] baudDiv,
  input  logic [OSR_W-1:0]  osrSel,
  output rxStrobe_t         strb
);
  localparam int BITCNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(DATA_BITS - 1);

  logic rxMeta, rxSync;
  logic [BAUD_W-1:0] baudCnt;
  logic tick;
  logic [OSR_W-1:0] osCnt, osNext, midPt;
  logic [BITCNT_W-1:0] bitCnt;
  rxState_t state;

  // two-flop synchroniser for the asynchronous line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  // oversampling tick; >= keeps it live when the divider is lowered
  assign tick = (baudCnt >= baudDiv);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baudCnt <= '0;
    else if (tick) baudCnt <= '0;
    else baudCnt <= baudCnt + 1'b1;
  end

  assign osNext = osCnt + 1'b1;
  assign midPt  = (osrSel >> 1) + OSR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      osCnt  <= '0;
      bitCnt <= '0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxSync) begin
            state <= ST_START;
            osCnt <= '0;
          end
        end
        ST_START: begin
          if (osNext == midPt) begin
            osCnt  <= '0;
            bitCnt <= '0;
            state  <= rxSync ? ST_IDLE : ST_DATA;
          end else begin
            osCnt <= osNext;
          end
        end
        ST_DATA: begin
          if (osCnt == osrSel) begin
            osCnt  <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_STOP;
          end else begin
            osCnt <= osNext;
          end
        end
        ST_STOP: begin
          if (osCnt == osrSel) begin
            osCnt <= '0;
            state <= ST_IDLE;
          end else begin
            osCnt <= osNext;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.bitVal   = rxSync;
    strb.stopOk   = rxSync;
    strb.busy     = (state != ST_IDLE);
    strb.shiftEn  = tick && (state == ST_DATA) && (osCnt == osrSel);
    strb.charDone = tick && (state == ST_STOP) && (osCnt == osrSel);
  end

  // R7: a detected start bit makes the receiver busy on the next cycle
  a_r7_busy_after_detect: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && tick && !rxSync) |=> strb.busy);

  // R8: a start bit that is high at mid-bit returns to idle
  a_r8_false_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick && osNext == midPt && rxSync) |=> (state == ST_IDLE));
endmodule

// File: rtl/rx_flow_dp.sv
module rx_flow_dp
  import rx_flow_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic                 readStb,
  input  logic                 rtsEnable,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 fullFlag,
  output logic                 frameErr,
  output logic                 overrunFlag,
  output logic                 rtsN
);
  logic [DATA_BITS-1:0] shiftReg;
  logic accept, readHit;

  assign readHit = readStb && fullFlag;
  assign accept  = strb.charDone && (!fullFlag || readStb);

  // bits arrive least significant first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.bitVal, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      fullFlag <= 1'b0;
      frameErr <= 1'b0;
    end else if (accept) begin
      rxByte   <= shiftReg;
      fullFlag <= 1'b1;
      frameErr <= !strb.stopOk;
    end else if (readHit) begin
      fullFlag <= 1'b0;
      frameErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunFlag <= 1'b0;
    else if (strb.charDone && fullFlag && !readStb) overrunFlag <= 1'b1;
    else if (readHit) overrunFlag <= 1'b0;
  end

  // stop the sender while occupied or while a character is arriving
  assign rtsN = rtsEnable && (fullFlag || strb.busy);

  a_r2_fill_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(strb.charDone));

  a_r3_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && fullFlag && !strb.charDone) |=> !fullFlag);

  a_r4_err_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> fullFlag);

  a_r5_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $stable(rxByte));
endmodule

// File: rtl/rx_flow_uart.sv
module rx_flow_uart
  import rx_flow_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BAUD_W    = 8,
  parameter int OSR_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxd,
  input  logic                 readStb,
  input  logic                 rtsEnable,
  input  logic [BAUD_W-1:0]    baudDiv,
  input  logic [OSR_W-1:0]     osrSel,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 fullFlag,
  output logic                 frameErr,
  output logic                 overrunFlag,
  output logic                 rtsN
);
  rxStrobe_t strb;

  rx_flow_ctrl #(.DATA_BITS(DATA_BITS), .BAUD_W(BAUD_W), .OSR_W(OSR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxd(rxd), .baudDiv(baudDiv), .osrSel(osrSel), .strb(strb)
  );

  rx_flow_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .readStb(readStb), .rtsEnable(rtsEnable),
    .rxByte(rxByte), .fullFlag(fullFlag), .frameErr(frameErr),
    .overrunFlag(overrunFlag), .rtsN(rtsN)
  );

  // R6: with flow control steady, rtsN only falls once the register is empty
  a_r6_rts_release: assert property (@(posedge clk) disable iff (!rstN)
    (rtsEnable && $past(rtsEnable) && $fell(rtsN)) |-> !fullFlag);
endmodule

// File: tb/rx_flow_uart_test.sv
module rx_flow_uart_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxd = 1'b1;
  logic readStb = 1'b0;
  logic rtsEnable = 1'b1;
  logic [7:0] baudDiv = 8'd1;
  logic [4:0] osrSel = 5'd15;
  logic [7:0] rxByte;
  logic fullFlag, frameErr, overrunFlag, rtsN;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rx_flow_uart uut (
    .clk(clk), .rstN(rstN), .rxd(rxd), .readStb(readStb), .rtsEnable(rtsEnable),
    .baudDiv(baudDiv), .osrSel(osrSel), .rxByte(rxByte), .fullFlag(fullFlag),
    .frameErr(frameErr), .overrunFlag(overrunFlag), .rtsN(rtsN)
  );

  // {data[15:8], stop[7], osr[6:3], baud[2:0]}
  localparam logic [15:0] VEC [6] = '{
    {8'hA5, 1'b1, 4'd15, 3'd1},
    {8'h3C, 1'b1, 4'd7,  3'd0},
    {8'h00, 1'b1, 4'd15, 3'd0},
    {8'hFF, 1'b1, 4'd7,  3'd2},
    {8'h81, 1'b0, 4'd15, 3'd1},
    {8'h5A, 1'b1, 4'd3,  3'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readPulse();
    @(negedge clk) readStb = 1'b1;
    @(negedge clk) readStb = 1'b0;
  endtask

  // probe: 0 none, 1 expect rtsN high and empty, 2 read mid-frame, 3 expect rtsN low
  task automatic sendFrame(input logic [7:0] data, input logic stopBit, input int probe);
    int bitClks;
    bitClks = (int'(baudDiv) + 1) * (int'(osrSel) + 1);
    rxd = 1'b0;
    idle(bitClks - 3);
    if (probe == 2) begin
      readPulse();
      @(negedge clk);
      chk("R7 read mid-frame empties", fullFlag, 0);
      chk("R7 rts held while frame in flight", rtsN, 1);
    end else begin
      idle(3);
      if (probe == 1) begin
        chk("R7 rts high after start detect", rtsN, 1);
        chk("R7 register still empty", fullFlag, 0);
      end else if (probe == 3) begin
        chk("R9 rts low in flight when disabled", rtsN, 0);
      end
    end
    for (int b = 0; b < 8; b++) begin
      rxd = data[b];
      idle(bitClks);
    end
    rxd = stopBit;
    idle(bitClks);
    rxd = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 full after reset", fullFlag, 0);
    chk("R1 frame error after reset", frameErr, 0);
    chk("R1 overrun after reset", overrunFlag, 0);
    chk("R1 rts after reset", rtsN, 0);

    // R2 R4 R10 table of frames under different timing
    for (int v = 0; v < 6; v++) begin
      osrSel  = {1'b0, VEC[v][6:3]};
      baudDiv = {5'd0, VEC[v][2:0]};
      idle(20);
      sendFrame(VEC[v][15:8], VEC[v][7], 0);
      chk("R2 R10 byte received", rxByte, VEC[v][15:8]);
      chk("R2 full set", fullFlag, 1);
      chk("R4 frame error matches stop", frameErr, !VEC[v][7]);
      chk("R6 rts high while full", rtsN, 1);
      readPulse();
      @(negedge clk);
      chk("R3 read clears full", fullFlag, 0);
      chk("R3 read clears frame error", frameErr, 0);
      chk("R6 rts released after read", rtsN, 0);
    end

    osrSel = 5'd15;
    baudDiv = 8'd1;
    idle(20);

    // R3 read when empty has no effect
    readPulse();
    @(negedge clk);
    chk("R3 empty read full", fullFlag, 0);
    chk("R3 empty read overrun", overrunFlag, 0);
    chk("R3 empty read rts", rtsN, 0);

    // R5 overrun
    sendFrame(8'h11, 1'b1, 0);
    chk("R5 first byte stored", rxByte, 8'h11);
    sendFrame(8'h22, 1'b1, 0);
    chk("R5 first byte kept", rxByte, 8'h11);
    chk("R5 overrun set", overrunFlag, 1);
    chk("R5 still full", fullFlag, 1);
    chk("R6 rts high on overrun", rtsN, 1);
    readPulse();
    @(negedge clk);
    chk("R3 read clears overrun", overrunFlag, 0);
    chk("R3 read clears full after overrun", fullFlag, 0);

    // R7 early deassert on start bit into empty register
    sendFrame(8'h96, 1'b1, 1);
    chk("R7 byte after probe", rxByte, 8'h96);
    chk("R7 rts high once stored", rtsN, 1);
    // R7 read while next frame arrives
    sendFrame(8'h3E, 1'b1, 2);
    chk("R7 mid-read frame stored", rxByte, 8'h3E);
    chk("R7 full after mid-read frame", fullFlag, 1);
    chk("R7 no overrun on mid-read", overrunFlag, 0);
    readPulse();
    @(negedge clk);
    chk("R7 rts low after final read", rtsN, 0);

    // R8 glitch shorter than half a bit
    rxd = 1'b0;
    idle(6);
    rxd = 1'b1;
    idle(6);
    chk("R8 rts high during candidate start", rtsN, 1);
    idle(40);
    chk("R8 rts back low after reject", rtsN, 0);
    chk("R8 nothing stored", fullFlag, 0);
    sendFrame(8'h42, 1'b1, 0);
    chk("R8 next frame received", rxByte, 8'h42);
    chk("R8 next frame full", fullFlag, 1);
    readPulse();
    idle(2);

    // R9 flow control disabled
    rtsEnable = 1'b0;
    sendFrame(8'h77, 1'b1, 3);
    chk("R9 byte stored with rts off", rxByte, 8'h77);
    chk("R9 rts low while full", rtsN, 0);
    @(negedge clk) rtsEnable = 1'b1;
    @(negedge clk);
    chk("R6 rts high when enabled and full", rtsN, 1);
    readPulse();
    @(negedge clk);
    chk("R6 rts low after read", rtsN, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule